// File: doc/BRIEF.md
# Berlekamp-Massey Key-Equation Solver

This block takes the sixteen syndromes of a received RS(255,239) block over GF(2^8) and turns them into the two polynomials that a later root search and magnitude stage need. It runs the Berlekamp-Massey iteration to find the error-locator polynomial σ(x). σ(x) is the connection polynomial of the shortest linear recurrence that reproduces the syndrome sequence. The block then forms the error-evaluator Ω(x) = S(x)·σ(x) mod x^16 and reports the recurrence length L. When L exceeds the correction limit of eight symbols, it flags the block as uncorrectable.

A caller presents all syndromes in parallel and pulses `start_i` for one cycle. The solver works through one iteration per clock, keeping a discrepancy, a correction polynomial and the inverse of the last non-zero discrepancy. It then forms the evaluator and pulses `done_o`. The results stay on the outputs until the next `done_o` pulse. The field arithmetic uses the primitive polynomial x^8+x^4+x^3+x^2+1 (0x11D) with α = 02. Division is done by exponentiation to the 254th power.

Top module: `ks_bm_solver`

## Requirements
- R1: While reset is held low, and after reset is released until the first result, `done_o`, `sigma_o`, `omega_o`, `len_o` and `fail_o` are all zero.
- R2: When `start_i` is sampled high in the idle state, `done_o` is high for exactly one cycle, 17 clock edges later. It is low in every other cycle.
- R3: A `start_i` pulse sampled while a block is in progress is ignored. It does not change the timing or the values of the pending result. A `start_i` sampled in the cycle where `done_o` is high is accepted.
- R4: The coefficient σ_i is output at `sigma_o[8i+7:8i]` for i = 0..8, and σ_0 is always 01.
- R5: Syndrome S_j is taken from `syn_i[8j+7:8j]`, with S_j = r(α^(j+1)). For 1 to 8 errors at distinct positions p (error term e·x^p), `len_o` equals the error count and `fail_o` is 0. σ(x) then has exactly `len_o` distinct roots among the 255 non-zero field elements, namely α^(−p).
- R6: Ω_i, output at `omega_o[8i+7:8i]` for i = 0..7, equals the XOR over j = 0..i of σ_j·S_(i−j).
- R7: All-zero syndromes give σ(x) = 1, Ω(x) = 0, `len_o` = 0 and `fail_o` = 0.
- R8: `fail_o` is 1 exactly when the recurrence length exceeds 8. `len_o` reports lengths up to 16. For example, syndromes that are zero except S_15 give length 16.
- R9: Between `done_o` pulses, all result outputs hold their values.
- R10: For any syndrome vector, `len_o` and the low nine coefficients of σ equal those of the shortest recurrence found by the Berlekamp-Massey rules: σ = 1, L = 0 at the start, and the length changes to r+1−L when the discrepancy is non-zero and 2L ≤ r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to solve the presented syndromes |
| syn_i | input | 128 | Syndromes S_0..S_15, S_j in bits 8j+7:8j |
| done_o | output | 1 | One-cycle pulse when results are updated |
| sigma_o | output | 72 | Error-locator coefficients σ_0..σ_8 |
| omega_o | output | 64 | Error-evaluator coefficients Ω_0..Ω_7 |
| len_o | output | 5 | Recurrence length L (0..16) |
| fail_o | output | 1 | Set when L exceeds 8 |

## Verification
All results become visible together, 17 clock edges after the edge that samples an accepted `start_i`. That is one edge to load, sixteen iterations, and one edge to form the evaluator and register the outputs. The bench records the edge at which each request is accepted and, on every falling clock edge, compares `done_o` and all result outputs against a behavioural model. It expects the pulse only at acceptance plus 17, and expects the last results held at all other times. Requests placed inside a busy window, and a request placed exactly on the `done_o` cycle, test the acceptance rule. After each decoded block, the locator on the ports is also evaluated at every field element to count and place its roots.

// File: rtl/ks_gf_pkg.sv
package ks_gf_pkg;
  localparam int GF_W = 8;
  localparam logic [GF_W:0] GF_POLY = 9'h11D;

  typedef logic [GF_W-1:0] gf_t;

  // shift-and-add product, reducing by the primitive polynomial
  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[GF_W-1] ? ((sh << 1) ^ GF_POLY[GF_W-1:0]) : (sh << 1);
    end
    return acc;
  endfunction

  // a^-1 = a^254 = a^2 * a^4 * ... * a^128
  function automatic gf_t gf_inv(gf_t a);
    gf_t pw;
    gf_t acc;
    pw  = a;
    acc = 8'h01;
    for (int i = 1; i < GF_W; i++) begin
      pw  = gf_mul(pw, pw);
      acc = gf_mul(acc, pw);
    end
    return acc;
  endfunction
endpackage

// File: rtl/ks_disc.sv
module ks_disc
  import ks_gf_pkg::*;
#(
  parameter int NPAR = 16,
  localparam int RW = $clog2(NPAR),
  localparam int NC = NPAR + 1
) (
  input  logic [NPAR*GF_W-1:0] syn,
  input  logic [NC*GF_W-1:0]   sig,
  input  logic [RW-1:0]        r,
  output gf_t                  d
);
  gf_t term [NPAR];

  // term i = sigma_i * S_(r-i) for i <= r
  for (genvar i = 0; i < NPAR; i++) begin : g_term
    logic [RW-1:0] idx;
    assign idx     = r - RW'(i);
    assign term[i] = (RW'(i) <= r) ?
                     gf_mul(sig[i*GF_W +: GF_W], syn[idx*GF_W +: GF_W]) : '0;
  end

  always_comb begin
    d = '0;
    for (int i = 0; i < NPAR; i++) d = d ^ term[i];
  end
endmodule

// File: rtl/ks_update.sv
module ks_update
  import ks_gf_pkg::*;
#(
  parameter int NPAR = 16,
  localparam int NC = NPAR + 1
) (
  input  logic [NC*GF_W-1:0] sig,
  input  logic [NC*GF_W-1:0] bsh,
  input  gf_t                coef,
  input  logic               lenchg,
  output logic [NC*GF_W-1:0] sig_nx,
  output logic [NC*GF_W-1:0] bsh_nx
);
  // bsh already carries the x^m shift; coef = d / b_prev
  for (genvar i = 0; i < NC; i++) begin : g_coef
    assign sig_nx[i*GF_W +: GF_W] = sig[i*GF_W +: GF_W] ^
                                    gf_mul(coef, bsh[i*GF_W +: GF_W]);
    if (i == 0) begin : g_low
      assign bsh_nx[GF_W-1:0] = '0;
    end else begin : g_up
      assign bsh_nx[i*GF_W +: GF_W] = lenchg ? sig[(i-1)*GF_W +: GF_W]
                                             : bsh[(i-1)*GF_W +: GF_W];
    end
  end
endmodule

// File: rtl/ks_omega.sv
module ks_omega
  import ks_gf_pkg::*;
#(
  parameter int NPAR = 16,
  parameter int NOM  = NPAR / 2,
  localparam int NC  = NPAR + 1
) (
  input  logic [NPAR*GF_W-1:0] syn,
  input  logic [NC*GF_W-1:0]   sig,
  output logic [NOM*GF_W-1:0]  omega
);
  for (genvar i = 0; i < NOM; i++) begin : g_om
    always_comb begin
      gf_t acc;
      acc = '0;
      for (int j = 0; j <= i; j++)
        acc = acc ^ gf_mul(sig[j*GF_W +: GF_W], syn[(i-j)*GF_W +: GF_W]);
      omega[i*GF_W +: GF_W] = acc;
    end
  end
endmodule

// File: rtl/ks_bm_solver.sv
module ks_bm_solver
  import ks_gf_pkg::*;
#(
  parameter int NPAR = 16,
  localparam int T   = NPAR / 2,
  localparam int NC  = NPAR + 1,
  localparam int NSO = T + 1,
  localparam int NOM = T,
  localparam int RW  = $clog2(NPAR),
  localparam int LW  = $clog2(NPAR + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [NPAR*GF_W-1:0]  syn_i,
  output logic                  done_o,
  output logic [NSO*GF_W-1:0]   sigma_o,
  output logic [NOM*GF_W-1:0]   omega_o,
  output logic [LW-1:0]         len_o,
  output logic                  fail_o
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_e;

  localparam logic [NC*GF_W-1:0] POLY_ONE = {{(NC*GF_W-1){1'b0}}, 1'b1};
  localparam logic [NC*GF_W-1:0] POLY_X   = POLY_ONE << GF_W;

  st_e                  st_q;
  logic [NPAR*GF_W-1:0] syn_q;
  logic [NC*GF_W-1:0]   sig_q, bsh_q, sig_nx, bsh_nx;
  logic [LW-1:0]        len_q;
  gf_t                  binv_q;
  logic [RW-1:0]        r_q;
  logic [NOM*GF_W-1:0]  omega_w;

  // named internal events
  gf_t  disc, coef;
  logic step, disc_nz, len_grow, last_iter;

  assign step      = (st_q == S_RUN);
  assign disc_nz   = (disc != '0);
  assign len_grow  = step && disc_nz && ({len_q, 1'b0} <= (LW+1)'(r_q));
  assign last_iter = (r_q == RW'(NPAR-1));
  assign coef      = gf_mul(disc, binv_q);

  ks_disc #(.NPAR(NPAR)) u_disc (
    .syn(syn_q), .sig(sig_q), .r(r_q), .d(disc)
  );

  ks_update #(.NPAR(NPAR)) u_upd (
    .sig(sig_q), .bsh(bsh_q), .coef(coef), .lenchg(len_grow),
    .sig_nx(sig_nx), .bsh_nx(bsh_nx)
  );

  ks_omega #(.NPAR(NPAR), .NOM(NOM)) u_omega (
    .syn(syn_q), .sig(sig_q), .omega(omega_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      syn_q   <= '0;
      sig_q   <= '0;
      bsh_q   <= '0;
      len_q   <= '0;
      binv_q  <= '0;
      r_q     <= '0;
      done_o  <= 1'b0;
      sigma_o <= '0;
      omega_o <= '0;
      len_o   <= '0;
      fail_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          syn_q  <= syn_i;
          sig_q  <= POLY_ONE;
          bsh_q  <= POLY_X;
          len_q  <= '0;
          binv_q <= 8'h01;
          r_q    <= '0;
          st_q   <= S_RUN;
        end
        S_RUN: begin
          sig_q <= sig_nx;
          bsh_q <= bsh_nx;
          if (len_grow) begin
            len_q  <= LW'(r_q) + LW'(1) - len_q;
            binv_q <= gf_inv(disc);
          end
          r_q <= r_q + RW'(1);
          if (last_iter) st_q <= S_FIN;
        end
        S_FIN: begin
          sigma_o <= sig_q[NSO*GF_W-1:0];
          omega_o <= omega_w;
          len_o   <= len_q;
          fail_o  <= (len_q > LW'(T));
          done_o  <= 1'b1;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R2
  AST_FIN_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FIN) |=> done_o); // R2
  AST_BUSY_KEEPS_SYN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && start_i) |=> $stable(syn_q)); // R3
  AST_SIGMA_MONIC: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sigma_o[GF_W-1:0] == 8'h01)); // R4
  AST_LEN_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (len_q >= $past(len_q))); // R5
  AST_ZERO_DISC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !disc_nz) |=> (sig_q == $past(sig_q))); // R5
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(sigma_o) && $stable(omega_o) && $stable(len_o))); // R9
endmodule

// File: tb/test_ks_bm_solver.sv
module test_ks_bm_solver;
  localparam int CLK_PERIOD = 10;
  localparam int NPAR = 16;
  localparam int NSO  = 9;
  localparam int NOM  = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [NPAR*8-1:0] syn_i = '0;
  logic             done_o;
  logic [NSO*8-1:0] sigma_o;
  logic [NOM*8-1:0] omega_o;
  logic [4:0]       len_o;
  logic             fail_o;

  ks_bm_solver i_ks_bm_solver (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .syn_i(syn_i),
    .done_o(done_o), .sigma_o(sigma_o), .omega_o(omega_o),
    .len_o(len_o), .fail_o(fail_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, due = -1000, last_acc = -1000;
  bit mon_on = 0;
  int gexp[512];
  int glog[256];
  int rs[16];
  int rc[17];
  int rL;
  int rom[8];
  int ipos[16];
  int pend_sig[9], pend_om[8], pend_len, pend_fail;
  int hold_sig[9], hold_om[8], hold_len, hold_fail;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[glog[a] + glog[b]];
  endfunction

  function automatic int gdiv(int a, int b);
    if (a == 0) return 0;
    return gexp[glog[a] + 255 - glog[b]];
  endfunction

  // textbook shortest-recurrence search on rs[]
  task automatic ref_run();
    int bb[17];
    int tt[17];
    int m, b, d, L, cf;
    for (int i = 0; i < 17; i++) begin rc[i] = 0; bb[i] = 0; end
    rc[0] = 1; bb[0] = 1; L = 0; m = 1; b = 1;
    for (int n = 0; n < 16; n++) begin
      d = rs[n];
      for (int i = 1; i <= L; i++) if (i <= n) d ^= gmul(rc[i], rs[n-i]);
      if (d == 0) m++;
      else begin
        cf = gdiv(d, b);
        tt = rc;
        for (int i = 0; i < 17; i++) if (i + m <= 16) rc[i+m] ^= gmul(cf, bb[i]);
        if (2*L <= n) begin
          L = n + 1 - L; bb = tt; b = d; m = 1;
        end else m++;
      end
    end
    rL = L;
    for (int i = 0; i < 8; i++) begin
      rom[i] = 0;
      for (int j = 0; j <= i; j++) rom[i] ^= gmul(rc[j], rs[i-j]);
    end
  endtask

  // full compare every falling edge: done timing and held results
  always @(negedge clk) begin
    bit ed;
    string tg;
    if (mon_on) begin
      ed = (cyc == due);
      if (ed) begin
        hold_sig = pend_sig; hold_om = pend_om;
        hold_len = pend_len; hold_fail = pend_fail;
      end
      chk("R2,R3 done pulse", int'(done_o), int'(ed));
      tg = ed ? "R10" : "R9";
      for (int i = 0; i < NSO; i++)
        chk({tg, " sigma coef"}, int'(sigma_o[i*8 +: 8]), hold_sig[i]);
      for (int i = 0; i < NOM; i++)
        chk({ed ? "R6" : "R9", " omega coef"}, int'(omega_o[i*8 +: 8]), hold_om[i]);
      chk({tg, " length"}, int'(len_o), hold_len);
      chk({ed ? "R8" : "R9", " fail flag"}, int'(fail_o), hold_fail);
    end
  end

  task automatic send();
    logic [NPAR*8-1:0] pk;
    ref_run();
    for (int j = 0; j < 16; j++) pk[j*8 +: 8] = 8'(rs[j]);
    @(negedge clk); #1;
    if (cyc + 1 >= last_acc + 18) begin
      last_acc = cyc + 1;
      due = cyc + 18;
      for (int i = 0; i < NSO; i++) pend_sig[i] = rc[i];
      pend_om = rom;
      pend_len = rL;
      pend_fail = (rL > 8) ? 1 : 0;
    end
    syn_i = pk; start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (cyc <= due + 1) @(negedge clk);
    #2;
  endtask

  task automatic inject(int nerr);
    int p, v, dup;
    for (int j = 0; j < 16; j++) rs[j] = 0;
    for (int k = 0; k < nerr; k++) begin
      do begin
        p = $urandom % 255; dup = 0;
        for (int q = 0; q < k; q++) if (ipos[q] == p) dup = 1;
      end while (dup);
      ipos[k] = p;
      v = ($urandom % 255) + 1;
      for (int j = 0; j < 16; j++) rs[j] ^= gmul(v, gexp[((j+1)*p) % 255]);
    end
  endtask

  function automatic int eval_sig(int x);
    int acc;
    acc = 0;
    for (int i = 0; i < NSO; i++)
      if (sigma_o[i*8 +: 8] != 0 && x != 0)
        acc ^= gexp[(glog[int'(sigma_o[i*8 +: 8])] + (i*glog[x]) % 255) % 255];
    return acc;
  endfunction

  task automatic root_check(int nerr);
    int cnt;
    cnt = 0;
    for (int i = 0; i < 255; i++) if (eval_sig(gexp[i]) == 0) cnt++;
    chk("R5 root count", cnt, nerr);
    chk("R5 length equals error count", int'(len_o), nerr);
    chk("R5 no fail", int'(fail_o), 0);
    for (int k = 0; k < nerr; k++)
      chk("R5 root at inverse locator", eval_sig(gexp[(255 - ipos[k]) % 255]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired, run hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    gexp[0] = 1;
    for (int i = 1; i < 512; i++) begin
      gexp[i] = gexp[i-1] << 1;
      if (gexp[i] & 256) gexp[i] ^= 'h11D;
    end
    for (int i = 0; i < 255; i++) glog[gexp[i]] = i;
    glog[0] = 0;
    for (int i = 0; i < 9; i++) hold_sig[i] = 0;
    for (int i = 0; i < 8; i++) hold_om[i] = 0;
    hold_len = 0; hold_fail = 0;

    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done_o), 0);
    chk("R1 sigma in reset", int'(sigma_o != 0), 0);
    chk("R1 omega in reset", int'(omega_o != 0), 0);
    chk("R1 length in reset", int'(len_o), 0);
    chk("R1 fail in reset", int'(fail_o), 0);
    #1 rst_n = 1'b1;
    mon_on = 1;
    repeat (4) @(negedge clk);

    // R7 all-zero syndromes
    for (int j = 0; j < 16; j++) rs[j] = 0;
    send(); wait_done();
    chk("R7 sigma is one", int'(sigma_o), 1);
    chk("R7 omega zero", int'(omega_o != 0), 0);
    chk("R7 length zero", int'(len_o), 0);
    chk("R4 sigma0 is 01", int'(sigma_o[7:0]), 1);

    // R5 correctable patterns, 1..8 errors
    for (int ne = 1; ne <= 8; ne++)
      for (int tr = 0; tr < 3; tr++) begin
        inject(ne); send(); wait_done(); root_check(ne);
        chk("R4 sigma0 is 01", int'(sigma_o[7:0]), 1);
      end

    // R3 second request inside busy window is dropped
    inject(3); send();
    repeat (4) @(negedge clk);
    inject(5); send();
    wait_done();
    inject(2);
    send();
    repeat (15) @(negedge clk);
    inject(7); send();
    wait_done();

    // R3 request sampled on the done cycle is accepted
    inject(4); send();
    while (cyc < due - 1) @(negedge clk);
    inject(6); send();
    wait_done();
    chk("R3 back-to-back length", int'(len_o), 6);

    // R8 long recurrence
    for (int j = 0; j < 16; j++) rs[j] = 0;
    rs[15] = 1;
    send(); wait_done();
    chk("R8 length 16", int'(len_o), 16);
    chk("R8 fail set", int'(fail_o), 1);

    for (int ne = 9; ne <= 12; ne++) begin
      inject(ne); send(); wait_done();
    end

    // R10 arbitrary syndromes
    for (int tr = 0; tr < 6; tr++) begin
      for (int j = 0; j < 16; j++) rs[j] = $urandom % 256;
      send(); wait_done();
    end

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule